// File: doc/BRIEF.md
# Pulse-Command Door Motor Controller

This block is a Moore state machine that runs a door motor from one push-button input and two end-of-travel sensors, one reporting the door fully raised and one reporting it fully lowered. The door cycles through four conditions: shut, rising, raised, lowering. Each condition is split into an "armed" state and a "pressed" state. A button press moves the machine from the armed state into the pressed state of the same condition. The release then moves it on to the armed state of the next condition. A press therefore counts as exactly one command, however many clock edges the button stays high.

The button and the two sensors are expected to be synchronous to the clock already. The outputs are the raise and lower commands for the motor and the 3-bit code of the present state. All three are decoded from the state register alone. Reset is synchronous and active high. It acts only on the state register.

Top module: `door_pulse_ctrl`

## Requirements
- R1: State codes are 0 shut_armed, 1 shut_pressed, 2 rising_armed, 3 rising_pressed, 4 raised_armed, 5 raised_pressed, 6 lowering_armed, 7 lowering_pressed. A clock edge with `rst` high puts the machine in code 0, with both motor outputs low.
- R2: In an armed state (even code), an edge that samples the button high moves the machine to the pressed state of the same condition (code + 1), unless R6 or R7 applies.
- R3: In a pressed state (odd code), an edge that samples the button still high leaves the state unchanged, unless R6 or R7 applies.
- R4: In a pressed state, an edge that samples the button low moves the machine to the armed state of the next condition: 1→2, 3→4, 5→6, 7→0.
- R5: In an armed state, an edge that samples the button low leaves the state unchanged, unless R6 or R7 applies.
- R6: In codes 2 or 3, an edge that samples the raised sensor high moves the machine to code 4, whatever the button does.
- R7: In codes 6 or 7, an edge that samples the lowered sensor high moves the machine to code 0, whatever the button does.
- R8: The raised sensor has no effect outside codes 2 and 3. The lowered sensor has no effect outside codes 6 and 7.
- R9: `motor_up_o` is high exactly in codes 2 and 3, and `motor_down_o` is high exactly in codes 6 and 7. The two are never high together.
- R10: A one-cycle press and a press held for several cycles produce the same sequence of distinct states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset to code 0 |
| btn_i | input | 1 | Push-button level, already synchronous |
| top_lim_i | input | 1 | High when the door is fully raised |
| bot_lim_i | input | 1 | High when the door is fully lowered |
| motor_up_o | output | 1 | Raise command to the motor |
| motor_down_o | output | 1 | Lower command to the motor |
| state_code_o | output | 3 | Present state code (see R1) |

## Verification
Every result is due at the first rising edge that samples a stimulus. The state code and both motor outputs change together, because the motor outputs are decoded from the registered state with no further register. The bench changes its inputs just after a falling edge and compares the outputs one time unit after the next rising edge. At that point it applies a next-state table of its own, written as explicit cases, to the inputs it has just driven. Held-button and pulse-width scenarios compare the state after every edge, not only at the end of a run.

// File: rtl/door_pulse_pkg.sv
package door_pulse_pkg;

  localparam int STATE_W = 3;
  localparam int COND_W  = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_SHUT_A  = 3'd0,
    ST_SHUT_P  = 3'd1,
    ST_RISE_A  = 3'd2,
    ST_RISE_P  = 3'd3,
    ST_RAISE_A = 3'd4,
    ST_RAISE_P = 3'd5,
    ST_LOWER_A = 3'd6,
    ST_LOWER_P = 3'd7
  } door_state_t;

  typedef enum logic [COND_W-1:0] {
    C_SHUT   = 2'd0,
    C_RISE   = 2'd1,
    C_RAISED = 2'd2,
    C_LOWER  = 2'd3
  } door_cond_t;

  // Condition of a state: the upper code bits.
  function automatic door_cond_t cond_of(input door_state_t s);
    return door_cond_t'(s[STATE_W-1:1]);
  endfunction

  // Pressed states carry an odd code.
  function automatic logic is_pressed(input door_state_t s);
    return s[0];
  endfunction

  // Pressed state of the same condition.
  function automatic door_state_t pressed_of(input door_cond_t c);
    return door_state_t'({c, 1'b1});
  endfunction

  // Armed state of the following condition, wrapping lowering to shut.
  function automatic door_state_t advance_of(input door_cond_t c);
    logic [COND_W-1:0] n;
    n = c + 1'b1;
    return door_state_t'({n, 1'b0});
  endfunction

  function automatic logic drives_up(input door_state_t s);
    return cond_of(s) == C_RISE;
  endfunction

  function automatic logic drives_down(input door_state_t s);
    return cond_of(s) == C_LOWER;
  endfunction

endpackage

// File: rtl/door_pulse_next.sv
module door_pulse_next
  import door_pulse_pkg::*;
(
  input  door_state_t cur_i,
  input  logic        btn_i,
  input  logic        top_lim_i,
  input  logic        bot_lim_i,
  output door_state_t nxt_o,
  output logic        ev_top_hit_o,
  output logic        ev_bot_hit_o,
  output logic        ev_press_o,
  output logic        ev_release_o
);

  door_cond_t cond;
  logic       pressed;

  assign cond    = cond_of(cur_i);
  assign pressed = is_pressed(cur_i);

  // Named events, in priority order: sensors before the button.
  assign ev_top_hit_o = (cond == C_RISE) && top_lim_i;
  assign ev_bot_hit_o = (cond == C_LOWER) && bot_lim_i;
  assign ev_press_o   = !ev_top_hit_o && !ev_bot_hit_o && !pressed && btn_i;
  assign ev_release_o = !ev_top_hit_o && !ev_bot_hit_o && pressed && !btn_i;

  always_comb begin
    nxt_o = cur_i;
    if (ev_top_hit_o) begin
      nxt_o = ST_RAISE_A;
    end else if (ev_bot_hit_o) begin
      nxt_o = ST_SHUT_A;
    end else if (ev_press_o) begin
      nxt_o = pressed_of(cond);
    end else if (ev_release_o) begin
      nxt_o = advance_of(cond);
    end
  end

endmodule

// File: rtl/door_pulse_state_reg.sv
module door_pulse_state_reg
  import door_pulse_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  door_state_t nxt_i,
  output door_state_t cur_o
);

  always_ff @(posedge clk) begin
    if (rst) cur_o <= ST_SHUT_A;
    else     cur_o <= nxt_i;
  end

  // R1: a reset edge always leaves the machine shut and armed.
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cur_o == ST_SHUT_A));

endmodule

// File: rtl/door_pulse_drive.sv
module door_pulse_drive
  import door_pulse_pkg::*;
(
  input  door_state_t                cur_i,
  output logic                       motor_up_o,
  output logic                       motor_down_o,
  output logic [STATE_W-1:0]         code_o
);

  assign motor_up_o   = drives_up(cur_i);
  assign motor_down_o = drives_down(cur_i);
  assign code_o       = cur_i;

  // R9: the motor is never told to go both ways.
  always_comb begin
    assert_motor_exclusive_R9: assert (!(motor_up_o && motor_down_o));
  end

endmodule

// File: rtl/door_pulse_ctrl.sv
module door_pulse_ctrl
  import door_pulse_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         btn_i,
  input  logic         top_lim_i,
  input  logic         bot_lim_i,
  output logic         motor_up_o,
  output logic         motor_down_o,
  output logic [2:0]   state_code_o
);

  door_state_t cur_q;
  door_state_t nxt;
  logic        ev_top_hit;
  logic        ev_bot_hit;
  logic        ev_press;
  logic        ev_release;

  door_pulse_next u_next (
    .cur_i        (cur_q),
    .btn_i        (btn_i),
    .top_lim_i    (top_lim_i),
    .bot_lim_i    (bot_lim_i),
    .nxt_o        (nxt),
    .ev_top_hit_o (ev_top_hit),
    .ev_bot_hit_o (ev_bot_hit),
    .ev_press_o   (ev_press),
    .ev_release_o (ev_release)
  );

  door_pulse_state_reg u_sreg (
    .clk   (clk),
    .rst   (rst),
    .nxt_i (nxt),
    .cur_o (cur_q)
  );

  door_pulse_drive u_drive (
    .cur_i        (cur_q),
    .motor_up_o   (motor_up_o),
    .motor_down_o (motor_down_o),
    .code_o       (state_code_o)
  );

  // R6: reaching the top while rising ends in raised_armed.
  assert_top_wins_R6: assert property (@(posedge clk) disable iff (rst)
    ev_top_hit |=> (state_code_o == 3'd4));

  // R7: reaching the bottom while lowering ends in shut_armed.
  assert_bot_wins_R7: assert property (@(posedge clk) disable iff (rst)
    ev_bot_hit |=> (state_code_o == 3'd0));

  // R3: a held button in a pressed state never advances further.
  assert_held_stays_R3: assert property (@(posedge clk) disable iff (rst)
    (state_code_o[0] && btn_i && !ev_top_hit && !ev_bot_hit)
      |=> $stable(state_code_o));

  // R2: a press in an armed state moves up by one code.
  assert_press_step_R2: assert property (@(posedge clk) disable iff (rst)
    ev_press |=> (state_code_o == $past(state_code_o) + 3'd1));

  // R4: a release lands on an armed state.
  assert_release_armed_R4: assert property (@(posedge clk) disable iff (rst)
    ev_release |=> !state_code_o[0]);

  // R9: motor outputs track rising and lowering conditions.
  assert_up_only_rising_R9: assert property (@(posedge clk) disable iff (rst)
    motor_up_o |-> (state_code_o[2:1] == 2'd1));

endmodule

// File: tb/door_pulse_ctrl_bench.sv
module door_pulse_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn = 1'b0;
  logic       top = 1'b0;
  logic       bot = 1'b0;
  logic       up, down;
  logic [2:0] code;

  int total = 0;
  int bad   = 0;
  logic [2:0] exp_code = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  door_pulse_ctrl u_door_pulse_ctrl (
    .clk          (clk),
    .rst          (rst),
    .btn_i        (btn),
    .top_lim_i    (top),
    .bot_lim_i    (bot),
    .motor_up_o   (up),
    .motor_down_o (down),
    .state_code_o (code)
  );

  // Next-state table written out case by case.
  function automatic logic [2:0] model_next(input logic [2:0] s, input logic b,
                                            input logic t, input logic d);
    case (s)
      3'd0: return b ? 3'd1 : 3'd0;
      3'd1: return b ? 3'd1 : 3'd2;
      3'd2: return t ? 3'd4 : (b ? 3'd3 : 3'd2);
      3'd3: return t ? 3'd4 : (b ? 3'd3 : 3'd4);
      3'd4: return b ? 3'd5 : 3'd4;
      3'd5: return b ? 3'd5 : 3'd6;
      3'd6: return d ? 3'd0 : (b ? 3'd7 : 3'd6);
      default: return d ? 3'd0 : (b ? 3'd7 : 3'd0);
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] e);
    logic eu, ed;
    eu = (e == 3'd2) || (e == 3'd3);
    ed = (e == 3'd6) || (e == 3'd7);
    total++;
    if (code !== e || up !== eu || down !== ed) begin
      bad++;
      $display("FAIL %s: code=%0d up=%0b down=%0b expected code=%0d up=%0b down=%0b",
               req, code, up, down, e, eu, ed);
    end
  endtask

  // Drive after a falling edge, sample one unit after the rising edge.
  task automatic step(input logic b, input logic t, input logic d, input string req);
    @(negedge clk);
    btn = b; top = t; bot = d;
    exp_code = model_next(exp_code, b, t, d);
    @(posedge clk);
    #1;
    check(req, exp_code);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; btn = 1'b1; top = 1'b1; bot = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    exp_code = 3'd0;
    check("R1 reset", 3'd0);
    @(negedge clk);
    rst = 1'b0; btn = 1'b0; top = 1'b0; bot = 1'b0;
  endtask

  task automatic t_full_cycle();
    t_reset();
    step(1, 0, 0, "R2 shut press");
    step(0, 0, 0, "R4 shut release");
    step(1, 0, 0, "R2 rising press");
    step(0, 0, 0, "R4 rising release");
    step(1, 0, 0, "R2 raised press");
    step(0, 0, 0, "R4 raised release");
    step(0, 0, 1, "R7 bottom reached");
    step(1, 0, 0, "R2 press again");
    step(0, 0, 0, "R4 to rising");
    step(1, 0, 0, "R2 rising press");
    step(0, 0, 0, "R4 to raised");
    step(1, 0, 0, "R2 raised press");
    step(0, 0, 0, "R4 to lowering");
    step(1, 0, 0, "R2 lowering press");
    step(0, 0, 0, "R4 lowering release wraps");
  endtask

  task automatic t_held_button();
    t_reset();
    step(0, 0, 0, "R5 idle armed");
    step(0, 0, 0, "R5 idle armed");
    step(1, 0, 0, "R2 first edge");
    for (int i = 0; i < 4; i++) step(1, 0, 0, "R3 held button");
    step(0, 0, 0, "R4 release");
    step(0, 0, 0, "R5 rising idle");
    step(1, 0, 0, "R2 rising press");
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R3 held in rising");
  endtask

  task automatic t_sensor_priority();
    t_reset();
    step(1, 0, 0, "R2 press");
    step(0, 0, 0, "R4 release");
    step(1, 1, 0, "R6 top beats press");
    step(1, 0, 0, "R2 raised press");
    step(0, 0, 0, "R4 to lowering");
    step(1, 0, 1, "R7 bottom beats press");
    step(1, 0, 0, "R2 press");
    step(0, 0, 0, "R4 release");
    step(1, 0, 0, "R2 rising press");
    step(1, 1, 0, "R6 top beats held button");
    step(0, 0, 0, "R5 raised idle");
    step(1, 0, 0, "R2 raised press");
    step(0, 0, 0, "R4 to lowering");
    step(1, 0, 0, "R2 lowering press");
    step(1, 0, 1, "R7 bottom beats held button");
  endtask

  task automatic t_ignored_sensors();
    t_reset();
    step(0, 1, 0, "R8 top ignored when shut");
    step(1, 1, 0, "R8 top ignored on shut press");
    step(0, 0, 0, "R4 release");
    step(0, 0, 1, "R8 bottom ignored while rising");
    step(1, 0, 0, "R2 press");
    step(0, 0, 0, "R4 to raised");
    step(0, 0, 1, "R8 bottom ignored when raised");
    step(0, 1, 0, "R8 top ignored when raised");
    step(1, 0, 0, "R2 press");
    step(0, 0, 0, "R4 to lowering");
    step(0, 1, 0, "R8 top ignored while lowering");
  endtask

  task automatic t_pulse_width();
    logic [2:0] narrow [4];
    logic [2:0] wide   [4];
    int n = 0;
    int w = 0;
    t_reset();
    for (int k = 0; k < 2; k++) begin
      step(1, 0, 0, "R10 narrow press");
      if (n < 4) narrow[n] = code;
      n++;
      step(0, 0, 0, "R10 narrow release");
      if (n < 4) narrow[n] = code;
      n++;
    end
    t_reset();
    for (int k = 0; k < 2; k++) begin
      step(1, 0, 0, "R10 wide press");
      if (w < 4) wide[w] = code;
      w++;
      for (int j = 0; j < 5; j++) begin
        step(1, 0, 0, "R10 wide hold");
        if (code != wide[w-1]) begin
          if (w < 4) wide[w] = code;
          w++;
        end
      end
      step(0, 0, 0, "R10 wide release");
      if (w < 4) wide[w] = code;
      w++;
    end
    total++;
    if (w != n) begin
      bad++;
      $display("FAIL R10 trace length: actual=%0d expected=%0d", w, n);
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (wide[i] !== narrow[i]) begin
          bad++;
          $display("FAIL R10 trace[%0d]: actual=%0d expected=%0d", i, wide[i], narrow[i]);
        end
      end
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_full_cycle();
    t_held_button();
    t_sensor_priority();
    t_ignored_sensors();
    t_pulse_width();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule